// File: doc/BRIEF.md
# Entropy Bitstream Health Monitor

This block watches a raw serial entropy stream, taking one bit on every cycle where `bit_valid` is high. It runs two statistical tests over consecutive, non-overlapping windows of 20,000 bits:

- a ones-count (monobit) test;
- a 4-bit pattern (poker) test, judged on the sum of squared bin counts.

Alongside the windowed tests it runs three checks on every bit:

- two detectors for stretches of identical bits, at 34 and at 48 bits;
- a detector that flags a 32-bit output word equal to the word before it.

Every failure produces a single-cycle event pulse. All event pulses feed a saturating failure counter. The counter is compared against a programmable threshold, and the result drives a sticky shutdown request.

The shutdown logic is a two-state machine:

- In `AL_ARMED`, the transition *trip* moves to `AL_TRIPPED`. It fires when the threshold is non-zero, the updated failure count is at or above the threshold, and no clear is requested.
- In `AL_TRIPPED`, the transition *release* returns to `AL_ARMED` when `shutdown_clear` is high.

`shutdown_req` is high exactly while the machine is in `AL_TRIPPED`. A system integrator connects the raw source to the bit inputs, programs `alarm_thresh`, and uses `shutdown_req` to stop consuming or generating entropy.

Top module: `entropy_health_mon`

## Requirements
- R1: While and after reset, all five event outputs and `shutdown_req` are low.
- R2: A bit is taken only in a cycle with `bit_valid` high. `bit_in` in any other cycle changes no test state, so an identical-bit stretch continues across idle cycles.
- R3: After each window of 20,000 taken bits, `evt_monobit` pulses for one cycle, on the cycle after the window's last bit, unless the ones count is strictly above 9654 and strictly below 10346.
- R4: Each window is cut into 5,000 nibbles, with the earliest bit as bit 3 of the nibble. The 16 per-value counts are squared and summed. `evt_poker` pulses on the cycle after the last bit unless that sum lies strictly between 1,563,176 and 1,576,928.
- R5: Windows do not overlap. Counts restart after each window, so back-to-back windows are judged independently.
- R6: `evt_longrun` pulses on the cycle after the 34th consecutive identical taken bit. It pulses only once per stretch, however long the stretch lasts.
- R7: `evt_noise` pulses on the cycle after the 48th consecutive identical taken bit. It also pulses only once per stretch.
- R8: Every 32 taken bits form a word, with the earliest bit as bit 31. `evt_stuck` pulses on the cycle after a word completes if it equals the previous word. The first word after reset is never flagged.
- R9: Each event pulse adds one to a failure count that saturates at 255. `shutdown_req` rises one cycle after the count reaches or exceeds a non-zero `alarm_thresh`, and then stays high. A threshold of zero never trips.
- R10: `shutdown_clear` zeroes the failure count, and `shutdown_req` is low on the following cycle. Clear takes priority over a trip in the same cycle.
- R11: Every event pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | `bit_in` carries a fresh entropy bit this cycle |
| bit_in | input | 1 | Raw entropy bit |
| alarm_thresh | input | 8 | Failure count that trips shutdown; 0 disables the trip |
| shutdown_clear | input | 1 | Releases shutdown and zeroes the failure count |
| evt_monobit | output | 1 | Window ones-count failure pulse |
| evt_poker | output | 1 | Window nibble-distribution failure pulse |
| evt_longrun | output | 1 | 34-bit identical stretch pulse |
| evt_noise | output | 1 | 48-bit identical stretch pulse |
| evt_stuck | output | 1 | Repeated 32-bit word pulse |
| shutdown_req | output | 1 | Sticky shutdown request |

## Verification
The assertions assume that `bit_valid` and `shutdown_clear` are clean, synchronous levels that are low during reset. They also assume that the window length is a multiple of four, so that a window always ends on a nibble boundary. The stimulus changes every input only on the falling clock edge and holds `bit_valid` low throughout reset. It toggles `bit_in` during idle cycles, so that any dependence on ignored bits becomes visible. It changes `alarm_thresh` only between bits, never while a trip decision is pending.

// File: rtl/ehm_pkg.sv
package ehm_pkg;

    typedef enum logic {
        AL_ARMED   = 1'b0,
        AL_TRIPPED = 1'b1
    } alarm_state_e;

    typedef struct packed {
        logic monobit;
        logic poker;
        logic longrun;
        logic noise;
        logic stuck;
    } health_evt_t;

endpackage

// File: rtl/ehm_window_stats.sv
module ehm_window_stats #(
    parameter int WINDOW_BITS = 20000,
    parameter int MONO_LO     = 9654,
    parameter int MONO_HI     = 10346,
    parameter int POKER_LO    = 1563176,
    parameter int POKER_HI    = 1576928
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic mono_fail,
    output logic poker_fail
);
    localparam int NIBBLES = WINDOW_BITS / 4;
    localparam int POS_W   = $clog2(WINDOW_BITS);
    localparam int ONES_W  = $clog2(WINDOW_BITS + 1);
    localparam int BIN_W   = $clog2(NIBBLES + 1);
    localparam int SUM_W   = $clog2(NIBBLES * NIBBLES + 1);
    localparam logic [POS_W-1:0]  LAST_POS = POS_W'(WINDOW_BITS - 1);
    localparam logic [ONES_W-1:0] ONES_LO  = ONES_W'(MONO_LO);
    localparam logic [ONES_W-1:0] ONES_HI  = ONES_W'(MONO_HI);
    localparam logic [SUM_W-1:0]  SQ_LO    = SUM_W'(POKER_LO);
    localparam logic [SUM_W-1:0]  SQ_HI    = SUM_W'(POKER_HI);

    logic [POS_W-1:0]  bit_pos;
    logic [ONES_W-1:0] ones_q;
    logic [ONES_W-1:0] ones_nx;
    logic [SUM_W-1:0]  sq_sum;
    logic [SUM_W-1:0]  sum_nx;
    logic [2:0]        nib_acc;
    logic [3:0]        nib_val;
    logic              nib_done;
    logic              win_end;
    logic [BIN_W-1:0]  bin_q [16];
    logic [BIN_W-1:0]  bin_sel;

    always_comb begin
        nib_val  = {nib_acc, bit_in};
        nib_done = (bit_pos[1:0] == 2'b11);
        win_end  = (bit_pos == LAST_POS);
        ones_nx  = ones_q + ONES_W'(bit_in);
        bin_sel  = bin_q[nib_val];
        // (c+1)^2 - c^2 = 2c+1: the square sum grows incrementally
        sum_nx   = nib_done ? sq_sum + {{(SUM_W-BIN_W-1){1'b0}}, bin_sel, 1'b1}
                            : sq_sum;
    end

    for (genvar g = 0; g < 16; g++) begin : g_bin
        logic [BIN_W-1:0] cnt;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (bit_valid) begin
                if (win_end)
                    cnt <= '0;
                else if (nib_done && nib_val == 4'(g))
                    cnt <= cnt + BIN_W'(1);
            end
        end
        assign bin_q[g] = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_pos    <= '0;
            ones_q     <= '0;
            sq_sum     <= '0;
            nib_acc    <= '0;
            mono_fail  <= 1'b0;
            poker_fail <= 1'b0;
        end else begin
            mono_fail  <= 1'b0;
            poker_fail <= 1'b0;
            if (bit_valid) begin
                nib_acc <= {nib_acc[1:0], bit_in};
                if (win_end) begin
                    bit_pos    <= '0;
                    ones_q     <= '0;
                    sq_sum     <= '0;
                    mono_fail  <= !((ones_nx > ONES_LO) && (ones_nx < ONES_HI));
                    poker_fail <= !((sum_nx > SQ_LO) && (sum_nx < SQ_HI));
                end else begin
                    bit_pos <= bit_pos + POS_W'(1);
                    ones_q  <= ones_nx;
                    sq_sum  <= sum_nx;
                end
            end
        end
    end

    // R3: a verdict only follows a taken bit
    p_mono_after_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mono_fail |-> $past(bit_valid));
    // R11: window verdicts never repeat on consecutive cycles
    p_poker_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        poker_fail |=> !poker_fail);
    p_mono_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mono_fail |=> !mono_fail);
endmodule

// File: rtl/ehm_run_detect.sv
module ehm_run_detect #(
    parameter int RUN_LEN = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic hit
);
    localparam int LEN_W = $clog2(RUN_LEN + 1);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(RUN_LEN);
    localparam logic [LEN_W-1:0] LEN_PRE = LEN_W'(RUN_LEN - 1);

    logic             seen;
    logic             last_bit;
    logic [LEN_W-1:0] run_len;
    logic             same;

    assign same = seen && (bit_in == last_bit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_bit <= 1'b0;
            run_len  <= '0;
            hit      <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (bit_valid) begin
                seen     <= 1'b1;
                last_bit <= bit_in;
                hit      <= same && (run_len == LEN_PRE);
                if (!same)
                    run_len <= LEN_W'(1);
                else if (run_len != LEN_MAX)
                    run_len <= run_len + LEN_W'(1);
            end
        end
    end

    // R6/R7: a stretch reports once, so pulses never touch
    p_run_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
    // R2: a hit only follows a taken bit
    p_run_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(bit_valid));
endmodule

// File: rtl/ehm_word_repeat.sv
module ehm_word_repeat #(
    parameter int WORD_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic hit
);
    localparam int POS_W = $clog2(WORD_W);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

    logic [WORD_W-2:0] shreg;
    logic [WORD_W-1:0] word_now;
    logic [WORD_W-1:0] prev_word;
    logic [POS_W-1:0]  wpos;
    logic              have_word;
    logic              word_done;

    assign word_now  = {shreg, bit_in};
    assign word_done = (wpos == LAST_POS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            prev_word <= '0;
            wpos      <= '0;
            have_word <= 1'b0;
            hit       <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (bit_valid) begin
                shreg <= word_now[WORD_W-2:0];
                if (word_done) begin
                    wpos      <= '0;
                    prev_word <= word_now;
                    have_word <= 1'b1;
                    hit       <= have_word && (word_now == prev_word);
                end else begin
                    wpos <= wpos + POS_W'(1);
                end
            end
        end
    end

    // R8: words are WORD_W bits apart, so flags never touch
    p_stuck_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/ehm_alarm_fsm.sv
module ehm_alarm_fsm
    import ehm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  health_evt_t      evt,
    input  logic [CNT_W-1:0] thresh,
    input  logic             clear,
    output logic             shutdown
);
    localparam int ADD_W = $clog2($bits(health_evt_t) + 1);

    alarm_state_e     state, state_nx;
    logic [CNT_W-1:0] fail_cnt;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W:0]   cnt_sum;
    logic [ADD_W-1:0] n_evt;
    logic             trip;

    always_comb begin
        n_evt    = ADD_W'($countones(evt));
        cnt_sum  = {1'b0, fail_cnt} + (CNT_W+1)'(n_evt);
        cnt_next = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
        trip     = (thresh != '0) && (cnt_next >= thresh);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            AL_ARMED:   if (!clear && trip) state_nx = AL_TRIPPED;
            AL_TRIPPED: if (clear)          state_nx = AL_ARMED;
            default:                        state_nx = AL_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= AL_ARMED;
            fail_cnt <= '0;
        end else begin
            state    <= state_nx;
            fail_cnt <= clear ? '0 : cnt_next;
        end
    end

    always_comb shutdown = (state == AL_TRIPPED);

    // R9: once raised, shutdown holds until cleared
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && !clear) |=> shutdown);
    // R9: a zero threshold never trips
    p_zero_thresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '0 && !shutdown) |=> !shutdown);
    // R10: clear always releases
    p_clear_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !shutdown);
endmodule

// File: rtl/entropy_health_mon.sv
module entropy_health_mon
    import ehm_pkg::*;
#(
    parameter int WINDOW_BITS = 20000,
    parameter int MONO_LO     = 9654,
    parameter int MONO_HI     = 10346,
    parameter int POKER_LO    = 1563176,
    parameter int POKER_HI    = 1576928,
    parameter int LONG_RUN    = 34,
    parameter int NOISE_RUN   = 48,
    parameter int WORD_W      = 32,
    parameter int ALARM_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_valid,
    input  logic               bit_in,
    input  logic [ALARM_W-1:0] alarm_thresh,
    input  logic               shutdown_clear,
    output logic               evt_monobit,
    output logic               evt_poker,
    output logic               evt_longrun,
    output logic               evt_noise,
    output logic               evt_stuck,
    output logic               shutdown_req
);
    health_evt_t evt;

    ehm_window_stats #(
        .WINDOW_BITS(WINDOW_BITS), .MONO_LO(MONO_LO), .MONO_HI(MONO_HI),
        .POKER_LO(POKER_LO), .POKER_HI(POKER_HI)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .mono_fail(evt.monobit), .poker_fail(evt.poker)
    );

    ehm_run_detect #(.RUN_LEN(LONG_RUN)) u_run_long (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .hit(evt.longrun)
    );

    ehm_run_detect #(.RUN_LEN(NOISE_RUN)) u_run_noise (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .hit(evt.noise)
    );

    ehm_word_repeat #(.WORD_W(WORD_W)) u_word (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .hit(evt.stuck)
    );

    ehm_alarm_fsm #(.CNT_W(ALARM_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .evt(evt), .thresh(alarm_thresh),
        .clear(shutdown_clear), .shutdown(shutdown_req)
    );

    assign evt_monobit = evt.monobit;
    assign evt_poker   = evt.poker;
    assign evt_longrun = evt.longrun;
    assign evt_noise   = evt.noise;
    assign evt_stuck   = evt.stuck;

    // R7: the 48-bit stretch can only complete after the 34-bit one has fired
    p_noise_not_with_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_noise |-> !evt_longrun);
endmodule

// File: tb/entropy_health_mon_tb.sv
`timescale 1ns/1ps
module entropy_health_mon_tb;
    localparam int WIN = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic [7:0] alarm_thresh = 8'd0;
    logic       shutdown_clear = 1'b0;
    logic       evt_monobit, evt_poker, evt_longrun, evt_noise, evt_stuck, shutdown_req;

    always #2 clk = ~clk;

    entropy_health_mon u_dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .alarm_thresh(alarm_thresh), .shutdown_clear(shutdown_clear),
        .evt_monobit(evt_monobit), .evt_poker(evt_poker), .evt_longrun(evt_longrun),
        .evt_noise(evt_noise), .evt_stuck(evt_stuck), .shutdown_req(shutdown_req)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic        m_prev;
    int          m_run;
    bit          m_have;
    logic [31:0] m_word, m_pw;
    int          m_wcnt;
    bit          m_hw;
    int          m_ones, m_pos;
    logic [3:0]  m_nib;
    int          m_bins [16];
    bit          v_mono, v_poker;
    int          e_long, e_noise, e_stuck, e_mono, e_poker;
    int          o_long, o_noise, o_stuck, o_mono, o_poker;
    logic [31:0] rng = 32'h1ACE_B00C;

    always @(negedge clk) begin
        if (rst_n) begin
            o_long  += int'(evt_longrun);
            o_noise += int'(evt_noise);
            o_stuck += int'(evt_stuck);
            o_mono  += int'(evt_monobit);
            o_poker += int'(evt_poker);
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic model_clear();
        m_prev = 1'b0; m_run = 0; m_have = 1'b0;
        m_word = '0; m_pw = '0; m_wcnt = 0; m_hw = 1'b0;
        m_ones = 0; m_pos = 0; m_nib = '0;
        for (int i = 0; i < 16; i++) m_bins[i] = 0;
        v_mono = 1'b0; v_poker = 1'b0;
        e_long = 0; e_noise = 0; e_stuck = 0; e_mono = 0; e_poker = 0;
        o_long = 0; o_noise = 0; o_stuck = 0; o_mono = 0; o_poker = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_valid = 1'b0; shutdown_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in = ~bit_in;   // R2: ignored while not valid
        end
    endtask

    task automatic send_bit(input logic b);
        longint s;
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in = b;
        if (m_have && b == m_prev) m_run++; else m_run = 1;
        m_have = 1'b1; m_prev = b;
        if (m_run == 34) e_long++;
        if (m_run == 48) e_noise++;
        m_word = {m_word[30:0], b};
        m_wcnt++;
        if (m_wcnt == 32) begin
            m_wcnt = 0;
            if (m_hw && m_word == m_pw) e_stuck++;
            m_pw = m_word; m_hw = 1'b1;
        end
        m_ones += int'(b);
        m_nib = {m_nib[2:0], b};
        m_pos++;
        if (m_pos % 4 == 0) m_bins[m_nib]++;
        if (m_pos == WIN) begin
            s = 0;
            for (int i = 0; i < 16; i++) s += longint'(m_bins[i]) * longint'(m_bins[i]);
            v_mono  = !(m_ones > 9654 && m_ones < 10346);
            v_poker = !(s > 1563176 && s < 1576928);
            e_mono  += int'(v_mono);
            e_poker += int'(v_poker);
            m_ones = 0; m_pos = 0;
            for (int i = 0; i < 16; i++) m_bins[i] = 0;
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) send_bit(w[i]);
    endtask

    // mode 0 random, 1 alternating, 2 k ones early, 3 k ones with early zeros
    task automatic send_window(input int mode, input int k);
        logic b;
        for (int i = 0; i < WIN; i++) begin
            unique case (mode)
                0: begin
                    rng = rng ^ (rng << 13);
                    rng = rng ^ (rng >> 17);
                    rng = rng ^ (rng << 5);
                    b = rng[0];
                end
                1: b = (i % 2 == 0);
                2: b = (i < 2 * k) && (i % 2 == 0);
                default: b = !((i < 2 * (WIN - k)) && (i % 2 == 1));
            endcase
            send_bit(b);
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic chk_counts(input string tag);
        idle(3);
        chk({tag, " R6 longrun count"}, o_long, e_long);
        chk({tag, " R7 noise count"}, o_noise, e_noise);
        chk({tag, " R8 stuck count"}, o_stuck, e_stuck);
        chk({tag, " R3 monobit count"}, o_mono, e_mono);
        chk({tag, " R4 poker count"}, o_poker, e_poker);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 events in reset", {evt_monobit, evt_poker, evt_longrun, evt_noise, evt_stuck}, 0);
        chk("R1 shutdown in reset", shutdown_req, 0);
        do_reset();
        @(negedge clk);
        chk("R1 events after reset", {evt_monobit, evt_poker, evt_longrun, evt_noise, evt_stuck}, 0);
        chk("R1 shutdown after reset", shutdown_req, 0);
    endtask

    task automatic t_runs();
        do_reset();
        alarm_thresh = 8'd0;
        send_bit(1'b0);
        repeat (20) send_bit(1'b1);
        idle(5);
        repeat (13) send_bit(1'b1);
        idle(1);
        chk("R6 no pulse at 33 (R2 gaps ignored)", o_long, 0);
        send_bit(1'b1);
        @(negedge clk);
        bit_valid = 1'b0;
        chk("R6 pulse after 34th bit", evt_longrun, 1);
        repeat (13) send_bit(1'b1);
        idle(1);
        chk("R7 no pulse at 47", o_noise, 0);
        send_bit(1'b1);
        @(negedge clk);
        bit_valid = 1'b0;
        chk("R7 pulse after 48th bit", evt_noise, 1);
        chk("R6 no repeat at 48", evt_longrun, 0);
        repeat (40) send_bit(1'b1);
        send_bit(1'b0);
        chk_counts("runs");
        chk("R6 once per stretch", o_long, 1);
        chk("R7 once per stretch", o_noise, 1);
    endtask

    task automatic t_stuck();
        do_reset();
        send_word(32'hDEADBEEF);
        idle(2);
        chk("R8 first word not flagged", o_stuck, 0);
        send_word(32'hDEADBEEF);
        @(negedge clk);
        bit_valid = 1'b0;
        chk("R8 repeat flagged", evt_stuck, 1);
        send_word(32'h12345678);
        chk_counts("stuck");
        // word held across a reset is forgotten
        do_reset();
        send_word(32'h12345678);
        idle(3);
        chk("R8 first word after reset", o_stuck, 0);
    endtask

    task automatic t_alarm();
        do_reset();
        alarm_thresh = 8'd3;
        repeat (3) send_word(32'hC0FFEE11);
        idle(3);
        chk("R9 below threshold", shutdown_req, 0);
        send_word(32'hC0FFEE11);
        @(negedge clk);
        bit_valid = 1'b0;
        chk("R8 third repeat", evt_stuck, 1);
        chk("R9 not yet tripped", shutdown_req, 0);
        @(negedge clk);
        chk("R9 tripped one cycle later", shutdown_req, 1);
        idle(6);
        chk("R9 sticky", shutdown_req, 1);
        @(negedge clk);
        shutdown_clear = 1'b1;
        @(negedge clk);
        shutdown_clear = 1'b0;
        chk("R10 released", shutdown_req, 0);
        repeat (2) send_word(32'hC0FFEE11);
        idle(3);
        chk("R10 count zeroed", shutdown_req, 0);
        alarm_thresh = 8'd0;
        send_word(32'hC0FFEE11);
        idle(3);
        chk("R9 zero threshold never trips", shutdown_req, 0);
        alarm_thresh = 8'd3;
        @(negedge clk);
        chk("R9 trips on reaching threshold", shutdown_req, 1);
        @(negedge clk);
        shutdown_clear = 1'b1;
        @(negedge clk);
        shutdown_clear = 1'b0;
        alarm_thresh = 8'd0;
    endtask

    task automatic t_windows();
        do_reset();
        alarm_thresh = 8'd0;
        send_window(0, 0);
        chk("R3 random window monobit", evt_monobit, v_mono);
        chk("R4 random window poker", evt_poker, v_poker);
        send_window(1, 0);
        chk("R5 back-to-back alt monobit passes", evt_monobit, 0);
        chk("R4 alt window poker fails", evt_poker, 1);
        chk_counts("windows R5");
    endtask

    task automatic t_mono_bounds();
        int kk [4] = '{9654, 9655, 10345, 10346};
        int md [4] = '{2, 2, 3, 3};
        int ex [4] = '{1, 0, 0, 1};
        for (int j = 0; j < 4; j++) begin
            do_reset();
            send_window(md[j], kk[j]);
            chk($sformatf("R3 monobit bound ones=%0d", kk[j]), evt_monobit, ex[j]);
            chk_counts("bounds");
        end
    endtask

    initial begin
        model_clear();
        t_reset();
        t_runs();
        t_stuck();
        t_alarm();
        t_windows();
        t_mono_bounds();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end
endmodule